// File: doc/BRIEF.md
# Universal Up/Down Loadable Counter

A synchronous binary counter, four bits wide by default, that a two-bit mode code steers each rising clock edge. The code picks one of four actions. The counter can keep its value, step up by one, step down by one, or take a parallel value from a data input. An active-low clear that is sampled on the clock edge forces the count to zero, whatever the mode code says.

The next count comes from toggle enables, not from an adder. When counting up, a bit flips when every bit below it is 1. When counting down, a bit flips when every bit below it is 0. The lowest bit flips on every counting step. A combinational terminal flag goes high when the count sits at the last value for the selected direction: all ones when counting up, all zeros when counting down. A parent block can use this flag to see that the next step will wrap.

All pins are plain control and status signals. The parallel value is taken in a single cycle, with no handshake, and nothing at the block's edge can hold it back.

Top module: `uc_counter`

## Requirements
- R1: When clr_n is 0 at a rising edge, the count becomes 0 after that edge, whatever mode and load_val are.
- R2: Mode code 2'b00 (hold) leaves the count unchanged across the edge.
- R3: Mode code 2'b01 (up) adds one per edge. Bit i flips when bits 0..i-1 are all 1. The count wraps from all ones to all zeros.
- R4: Mode code 2'b10 (down) subtracts one per edge. Bit i flips when bits 0..i-1 are all 0. The count wraps from all zeros to all ones.
- R5: Mode code 2'b11 (load) copies load_val into the count on the edge. load_val bit i goes to count bit i.
- R6: term is combinational. It is 1 exactly when mode is up and the count is all ones, or when mode is down and the count is all zeros. It is 0 in hold and load modes.
- R7: load_val has no effect on the count in the hold, up and down modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, takes priority over every mode |
| mode | input | 2 | 00 hold, 01 up, 10 down, 11 load |
| load_val | input | WIDTH | Parallel value taken in load mode |
| count | output | WIDTH | Current count |
| term | output | 1 | Terminal count for the selected direction |

## Verification
The test starts with long runs of up and down counting that pass through the wrap points. These runs check the toggle chains at every carry depth, and they show whether term goes high on the right end value for each direction. Hold cycles and counting cycles are run while load_val changes. This shows that the data input is ignored outside load mode, and that hold does not drift. Loads are made just before a wrap, and clear is asserted while the mode is up or load. These cases show that clear wins over every mode and that a load sets where counting starts from. A final stretch of pseudo-random modes, data and clears is compared against a behavioural model on every cycle.

// File: rtl/uc_pkg.sv
package uc_pkg;
  typedef enum logic [1:0] {
    UC_HOLD = 2'b00,
    UC_UP   = 2'b01,
    UC_DOWN = 2'b10,
    UC_LOAD = 2'b11
  } uc_mode_e;
endpackage

// File: rtl/uc_toggle_chain.sv
module uc_toggle_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH:0]   ones_below,
  output logic [WIDTH:0]   zeros_below
);
  assign ones_below[0]  = 1'b1;
  assign zeros_below[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign ones_below[i+1]  = ones_below[i]  &  q[i];
    assign zeros_below[i+1] = zeros_below[i] & ~q[i];
  end
endmodule

// File: rtl/uc_next_sel.sv
module uc_next_sel
  import uc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  uc_mode_e         mode,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] up_tgl,
  input  logic [WIDTH-1:0] dn_tgl,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] q_next
);
  always_comb begin
    unique case (mode)
      UC_HOLD: q_next = q;
      UC_UP:   q_next = q ^ up_tgl;
      UC_DOWN: q_next = q ^ dn_tgl;
      UC_LOAD: q_next = load_val;
      default: q_next = q;
    endcase
  end
endmodule

// File: rtl/uc_state_reg.sv
module uc_state_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!clr_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/uc_counter.sv
module uc_counter
  import uc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             term
);
  localparam int CHAIN = WIDTH + 1;

  uc_mode_e         mode_e;
  logic [CHAIN-1:0] ones_below;
  logic [CHAIN-1:0] zeros_below;
  logic [WIDTH-1:0] q_next;

  assign mode_e = uc_mode_e'(mode);

  uc_toggle_chain #(.WIDTH(WIDTH)) u_chain (
    .q           (count),
    .ones_below  (ones_below),
    .zeros_below (zeros_below)
  );

  uc_next_sel #(.WIDTH(WIDTH)) u_sel (
    .mode     (mode_e),
    .q        (count),
    .up_tgl   (ones_below[WIDTH-1:0]),
    .dn_tgl   (zeros_below[WIDTH-1:0]),
    .load_val (load_val),
    .q_next   (q_next)
  );

  uc_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (q_next),
    .q     (count)
  );

  assign term = ((mode_e == UC_UP)   && ones_below[WIDTH]) ||
                ((mode_e == UC_DOWN) && zeros_below[WIDTH]);
endmodule

// File: rtl/uc_counter_chk.sv
module uc_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] load_val,
  input logic [WIDTH-1:0] count,
  input logic             term
);
  logic past_valid = 1'b0;
  logic clr_seen   = 1'b0;
  always_ff @(posedge clk) begin
    past_valid <= 1'b1;
    clr_seen   <= !clr_n;
  end

  // R1: a clear sampled on the previous edge leaves zero
  always_ff @(posedge clk) begin
    if (past_valid && clr_seen)
      p_clear_zero_r1: assert (count == '0);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!clr_n)
    past_valid && $past(clr_n) && $past(mode) == 2'b00 |-> $stable(count));

  p_up_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
    past_valid && $past(clr_n) && $past(mode) == 2'b01
      |-> count == WIDTH'($past(count) + 1'b1));

  p_down_step_r4: assert property (@(posedge clk) disable iff (!clr_n)
    past_valid && $past(clr_n) && $past(mode) == 2'b10
      |-> count == WIDTH'($past(count) - 1'b1));

  p_load_r5: assert property (@(posedge clk) disable iff (!clr_n)
    past_valid && $past(clr_n) && $past(mode) == 2'b11
      |-> count == $past(load_val));

  p_term_quiet_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b00 || mode == 2'b11) |-> !term);
endmodule

bind uc_counter uc_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .mode     (mode),
  .load_val (load_val),
  .count    (count),
  .term     (term)
);

// File: tb/uc_counter_test.sv
`timescale 1ns/1ps
module uc_counter_test;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] count;
  logic         term;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  uc_counter #(.WIDTH(W)) uut (
    .clk(clk), .clr_n(clr_n), .mode(mode), .load_val(load_val),
    .count(count), .term(term)
  );

  task automatic step(input logic [1:0] m, input int d, input logic c);
    int nxt;
    string tag;
    int exp_term;
    @(negedge clk);
    mode = m; load_val = W'(d); clr_n = c;
    if (!c) begin nxt = 0; tag = "R1"; end
    else case (m)
      2'b00: begin nxt = exp_cnt; tag = "R2/R7"; end
      2'b01: begin nxt = (exp_cnt + 1) % (MAXV + 1); tag = "R3/R7"; end
      2'b10: begin nxt = (exp_cnt + MAXV) % (MAXV + 1); tag = "R4/R7"; end
      default: begin nxt = d % (MAXV + 1); tag = "R5"; end
    endcase
    @(posedge clk); #1;
    exp_cnt = nxt;
    n_cmp++;
    if (int'(count) != exp_cnt) begin
      n_bad++;
      $display("FAIL %s count actual=%0d expected=%0d", tag, count, exp_cnt);
    end
    exp_term = ((m == 2'b01 && exp_cnt == MAXV) || (m == 2'b10 && exp_cnt == 0)) ? 1 : 0;
    n_cmp++;
    if (int'(term) != exp_term) begin
      n_bad++;
      $display("FAIL R6 term actual=%0d expected=%0d", term, exp_term);
    end
  endtask

  initial begin
    // R1: reset state
    step(2'b01, 5, 1'b0);
    step(2'b11, 9, 1'b0);
    // R3: full up run with wrap, R7 data toggling
    for (int i = 0; i < 20; i++) step(2'b01, i * 7, 1'b1);
    // R2: hold with changing data
    for (int i = 0; i < 4; i++) step(2'b00, 15 - i, 1'b1);
    // R5: load then R4 down through wrap
    step(2'b11, 10, 1'b1);
    for (int i = 0; i < 14; i++) step(2'b10, i * 3, 1'b1);
    // R5 + R4: load zero then wrap down
    step(2'b11, 0, 1'b1);
    step(2'b10, 6, 1'b1);
    step(2'b10, 6, 1'b1);
    // R5 + R3: load all ones then wrap up
    step(2'b11, MAXV, 1'b1);
    step(2'b01, 3, 1'b1);
    // R1: clear wins over up and load
    step(2'b01, 3, 1'b1);
    step(2'b01, 3, 1'b0);
    step(2'b11, 12, 1'b1);
    step(2'b11, 7, 1'b0);
    // mixed pseudo-random stretch
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[1:0], int'(lfsr[7:4]), (lfsr[11:8] != 4'd0));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule